// File: doc/BRIEF.md
# DMA Channel Command and Status Register Block

This block is the register front end of one channel of a scatter-gather DMA engine. Software reaches it through a plain 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for the presented address. It turns writes to a command word into one-cycle strobes for the data engine. It holds the channel configuration, it keeps a set of sticky status flags raised by event pulses from the engine, and it drives a level interrupt. It also exposes a device-side byte counter and a view of the channel FIFO occupancy.

Interrupt enables are never written by read-modify-write. Each enable has its own set bit and clear bit in the control word, so a write that carries only zeros for a pair leaves that enable as it was. Status flags stay raised until software writes the matching clear strobe to the command word, so an event is not lost between a status read and the following acknowledge. Moving data, bus mastering and descriptor fetch belong to the engine behind this block.

Register offsets (byte address, bits 1:0 ignored): 0x00 command (write-only, reads 0), 0x04 control, 0x08 device byte count, 0x0C FIFO occupancy (read-only), 0x10 status (read-only). Any other offset reads 0.

Top module: `dma_chan_regs`

## Requirements
- R1: A write to offset 0x00 raises, during that write cycle only, go_start, go_cont, go_stop, go_abort and go_fifo_rst for command bits 0, 1, 2, 3 and 4; when bit 31 is also 1 none of them is raised. Offset 0x00 reads back 0.
- R2: A control write stores bit 15 (FIFO off), bit 14 (burst), bit 6 (device byte swap), bit 4 (memory byte swap), bit 3 (direction, 1 = device to memory) and bits 2:0 (mode, stored as written); they read back at the same positions and drive the cfg_* outputs.
- R3: The enables for master, link-pause, done, memory-ready, device-ready, link-complete and ring event have set bits 31, 29, 25, 23, 21, 19, 17, each with its clear bit one position lower. A 1 in the set bit enables, a 1 in the clear bit disables and wins over a set in the same write, and zeros leave the enable unchanged. Each enable reads back at its set-bit position; clear-bit positions and bits 27, 26 read 0.
- R4: Reset, and a command write with bit 31 set, clear all enables, configuration fields, status flags, the running state and the byte counter; that write performs nothing else.
- R5: Status bit 25 (done) is set by ev_chain_done and status bit 19 (link complete) by ev_link_done. Done clears only by command bit 7 or a start; link complete only by command bit 5. An event in the same cycle as its clear leaves the flag set.
- R6: A start sets the running state and clears the done, stopped, software-abort, hardware-abort and transfer-error flags. Stop clears running and sets status bit 12; abort clears running and sets status bit 14; ev_chain_done also clears running. Any of these stopping causes wins over a start in the same cycle.
- R7: ev_xfer_err clears running and sets status bit 9 (transfer error) and bit 13 (hardware abort); status bit 15 (error) reads as the OR of bits 9 and 13. Both clear only on start.
- R8: irq and status bit 31 equal the master enable ANDed with the OR of (link-paused and its enable), (done and its enable), (link complete and its enable) and (ring event and its enable).
- R9: A write to offset 0x08 loads the byte counter; otherwise each cycle with ev_byte_vld adds ev_byte_cnt to it. A write in the same cycle as a byte event takes the written value.
- R10: Offset 0x0C reads the filled count fifo_fill in bits 7:0 and FIFO_DEPTH minus fifo_fill in bits 23:16, all other bits 0.
- R11: Status bit 29 (link paused) is set by ev_link_pause and cleared by a continue strobe; bit 17 (ring event) is set by ev_ring_event and cleared by command bit 6, an event winning over its clear. Bit 8 reads 1 when the channel is not running, and bits 7 and 6 follow drq_in[1] and drq_in[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| ev_link_done | input | 1 | Engine pulse: one descriptor finished |
| ev_chain_done | input | 1 | Engine pulse: whole transfer finished |
| ev_link_pause | input | 1 | Engine pulse: chain paused at a link |
| ev_ring_event | input | 1 | Engine pulse: continue or ring wrap event |
| ev_xfer_err | input | 1 | Engine pulse: transfer error |
| ev_byte_vld | input | 1 | Device-side bytes moved this cycle |
| ev_byte_cnt | input | BCNT_W | Number of bytes moved |
| fifo_fill | input | FILL_W | Filled FIFO slots |
| drq_in | input | 2 | Device request lines |
| irq | output | 1 | Level interrupt |
| chan_run | output | 1 | Channel running |
| go_start | output | 1 | Start strobe |
| go_cont | output | 1 | Continue strobe |
| go_stop | output | 1 | Stop strobe |
| go_abort | output | 1 | Abort strobe |
| go_fifo_rst | output | 1 | FIFO reset strobe |
| cfg_mode | output | 3 | Transfer mode |
| cfg_dir | output | 1 | Direction, 1 = device to memory |
| cfg_burst | output | 1 | Burst enable |
| cfg_fifo_off | output | 1 | FIFO disable |
| cfg_swap_dev | output | 1 | Device-side byte swap |
| cfg_swap_mem | output | 1 | Memory-side byte swap |

## Verification
The assertions take for granted that engine event pulses may arrive in any cycle, including the cycle of a command write that clears the same flag, and that fifo_fill never exceeds FIFO_DEPTH. The stimulus draws fill levels only from 0 to FIFO_DEPTH and freely overlaps events with command, control and counter writes, so the event-over-clear, clear-over-set and write-over-accumulate orderings are all reached. Channel reset writes are kept rare so that flags and enables build up between them.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int REG_W  = 32;
    localparam int N_IEN  = 7;

    // Word index of each register (byte address bits above 1:0)
    localparam int WI_CMD  = 0;
    localparam int WI_CTRL = 1;
    localparam int WI_DCNT = 2;
    localparam int WI_FIFO = 3;
    localparam int WI_STAT = 4;

    // Status word bit positions
    localparam int SB_IRQ    = 31;
    localparam int SB_LPAUSE = 29;
    localparam int SB_DONE   = 25;
    localparam int SB_LINK   = 19;
    localparam int SB_RING   = 17;
    localparam int SB_ERR    = 15;
    localparam int SB_SWAB   = 14;
    localparam int SB_HWAB   = 13;
    localparam int SB_STOP   = 12;
    localparam int SB_XFERR  = 9;
    localparam int SB_END    = 8;
    localparam int SB_DRQ1   = 7;
    localparam int SB_DRQ0   = 6;

    typedef struct packed {
        logic chan_rst;
        logic clr_done;
        logic clr_ring;
        logic clr_link;
        logic fifo_rst;
        logic abort;
        logic stop;
        logic cont;
        logic start;
    } cmd_t;

    // bit i of the packed value is enable i
    typedef struct packed {
        logic ring;    // 6
        logic link;    // 5
        logic drdy;    // 4
        logic mrdy;    // 3
        logic done;    // 2
        logic lpause;  // 1
        logic master;  // 0
    } ien_t;

    typedef struct packed {
        logic       fifo_off;
        logic       burst;
        logic       swap_dev;
        logic       swap_mem;
        logic       dir;
        logic [2:0] mode;
    } cfg_t;

    typedef struct packed {
        logic lpause;
        logic done;
        logic link;
        logic ring;
        logic swabort;
        logic hwabort;
        logic stopped;
        logic xferr;
    } flags_t;

    // Position of the set bit of enable i; its clear bit sits one lower
    function automatic int ien_set_pos(input int i);
        case (i)
            0:       return 31;
            1:       return 29;
            2:       return 25;
            3:       return 23;
            4:       return 21;
            5:       return 19;
            default: return 17;
        endcase
    endfunction

    // Command word to strobes; a channel reset suppresses the rest
    function automatic cmd_t decode_cmd(input logic hit, input logic [REG_W-1:0] w);
        cmd_t c;
        logic live;
        live       = hit && !w[31];
        c.chan_rst = hit && w[31];
        c.start    = live && w[0];
        c.cont     = live && w[1];
        c.stop     = live && w[2];
        c.abort    = live && w[3];
        c.fifo_rst = live && w[4];
        c.clr_link = live && w[5];
        c.clr_ring = live && w[6];
        c.clr_done = live && w[7];
        return c;
    endfunction

endpackage

// File: rtl/dcr_cmd_decode.sv
module dcr_cmd_decode
    import dcr_pkg::*;
(
    input  logic             hit,
    input  logic [REG_W-1:0] wdata,
    output cmd_t             cmd
);
    logic unused_hi;
    assign unused_hi = ^wdata[30:8];

    assign cmd = decode_cmd(hit, wdata);

endmodule

// File: rtl/dcr_ctrl_reg.sv
module dcr_ctrl_reg
    import dcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg,
    output ien_t             ien,
    output logic [REG_W-1:0] rd_word
);
    logic [N_IEN-1:0] en_vec;

    generate
        for (genvar i = 0; i < N_IEN; i++) begin : g_en
            localparam int SP = ien_set_pos(i);
            logic q;
            always_ff @(posedge clk) begin
                if (rst || chan_rst) begin
                    q <= 1'b0;
                end else if (wr) begin
                    if (wdata[SP-1])
                        q <= 1'b0;
                    else if (wdata[SP])
                        q <= 1'b1;
                end
            end
            assign en_vec[i] = q;
        end
    endgenerate

    assign ien = ien_t'(en_vec);

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.fifo_off <= wdata[15];
            cfg.burst    <= wdata[14];
            cfg.swap_dev <= wdata[6];
            cfg.swap_mem <= wdata[4];
            cfg.dir      <= wdata[3];
            cfg.mode     <= wdata[2:0];
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_IEN; i++)
            rd_word[ien_set_pos(i)] = en_vec[i];
        rd_word[15]  = cfg.fifo_off;
        rd_word[14]  = cfg.burst;
        rd_word[6]   = cfg.swap_dev;
        rd_word[4]   = cfg.swap_mem;
        rd_word[3]   = cfg.dir;
        rd_word[2:0] = cfg.mode;
    end

    logic unused_bits;
    assign unused_bits = ^{wdata[27:26], wdata[13:7], wdata[5]};

    // R3: a clear bit overrides its set bit in the same write
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[30] && wdata[31]) |=> !ien.master);

    // R3: a write with zeros in a pair leaves that enable alone
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr && !chan_rst && !wdata[25] && !wdata[24]) |=> (ien.done == $past(ien.done)));

    // R4: channel reset leaves every enable cleared
    a_r4_ien_cleared: assert property (@(posedge clk) disable iff (rst)
        chan_rst |=> (ien == '0 && cfg == '0));

endmodule

// File: rtl/dcr_status.sv
module dcr_status
    import dcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmd_t             cmd,
    input  ien_t             ien,
    input  logic             ev_link_done,
    input  logic             ev_chain_done,
    input  logic             ev_link_pause,
    input  logic             ev_ring_event,
    input  logic             ev_xfer_err,
    input  logic [1:0]       drq_in,
    output flags_t           flags,
    output logic             run,
    output logic             irq,
    output logic [REG_W-1:0] stat_word
);
    logic halt;
    assign halt = ev_xfer_err || cmd.abort || cmd.stop || ev_chain_done;

    always_ff @(posedge clk) begin
        if (rst || cmd.chan_rst) begin
            flags <= '0;
            run   <= 1'b0;
        end else begin
            // engine events win over software clears in the same cycle
            if (ev_chain_done)              flags.done <= 1'b1;
            else if (cmd.clr_done || cmd.start) flags.done <= 1'b0;

            if (ev_link_done)               flags.link <= 1'b1;
            else if (cmd.clr_link)          flags.link <= 1'b0;

            if (ev_ring_event)              flags.ring <= 1'b1;
            else if (cmd.clr_ring)          flags.ring <= 1'b0;

            if (ev_link_pause)              flags.lpause <= 1'b1;
            else if (cmd.cont)              flags.lpause <= 1'b0;

            if (ev_xfer_err) begin
                flags.xferr   <= 1'b1;
                flags.hwabort <= 1'b1;
            end else if (cmd.start) begin
                flags.xferr   <= 1'b0;
                flags.hwabort <= 1'b0;
            end

            if (cmd.abort)                  flags.swabort <= 1'b1;
            else if (cmd.start)             flags.swabort <= 1'b0;

            if (cmd.stop)                   flags.stopped <= 1'b1;
            else if (cmd.start)             flags.stopped <= 1'b0;

            if (halt)                       run <= 1'b0;
            else if (cmd.start)             run <= 1'b1;
        end
    end

    assign irq = ien.master && ((flags.lpause && ien.lpause) ||
                                (flags.done   && ien.done)   ||
                                (flags.link   && ien.link)   ||
                                (flags.ring   && ien.ring));

    always_comb begin
        stat_word            = '0;
        stat_word[SB_IRQ]    = irq;
        stat_word[SB_LPAUSE] = flags.lpause;
        stat_word[SB_DONE]   = flags.done;
        stat_word[SB_LINK]   = flags.link;
        stat_word[SB_RING]   = flags.ring;
        stat_word[SB_ERR]    = flags.xferr || flags.hwabort;
        stat_word[SB_SWAB]   = flags.swabort;
        stat_word[SB_HWAB]   = flags.hwabort;
        stat_word[SB_STOP]   = flags.stopped;
        stat_word[SB_XFERR]  = flags.xferr;
        stat_word[SB_END]    = !run;
        stat_word[SB_DRQ1]   = drq_in[1];
        stat_word[SB_DRQ0]   = drq_in[0];
    end

    logic unused_en;
    assign unused_en = ien.mrdy ^ ien.drdy ^ cmd.fifo_rst;

    // R5: done stays raised until cleared by strobe or start
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags.done && !cmd.clr_done && !cmd.start && !cmd.chan_rst) |=> flags.done);

    // R5: link complete survives everything but its own strobe
    a_r5_link_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags.link && !cmd.clr_link && !cmd.chan_rst) |=> flags.link);

    // R6: an uncontested start leaves the channel running
    a_r6_start_runs: assert property (@(posedge clk) disable iff (rst)
        (cmd.start && !halt && !cmd.chan_rst) |=> run);

    // R7: a transfer error halts the channel and latches
    a_r7_err_halts: assert property (@(posedge clk) disable iff (rst)
        (ev_xfer_err && !cmd.chan_rst) |=> (!run && flags.xferr && flags.hwabort));

    // R8: no interrupt without the master enable
    a_r8_irq_master: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien.master);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dcr_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int FIFO_DEPTH = 64,
    parameter int BCNT_W     = 8,
    parameter int FILL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_link_done,
    input  logic              ev_chain_done,
    input  logic              ev_link_pause,
    input  logic              ev_ring_event,
    input  logic              ev_xfer_err,
    input  logic              ev_byte_vld,
    input  logic [BCNT_W-1:0] ev_byte_cnt,
    input  logic [FILL_W-1:0] fifo_fill,
    input  logic [1:0]        drq_in,
    output logic              irq,
    output logic              chan_run,
    output logic              go_start,
    output logic              go_cont,
    output logic              go_stop,
    output logic              go_abort,
    output logic              go_fifo_rst,
    output logic [2:0]        cfg_mode,
    output logic              cfg_dir,
    output logic              cfg_burst,
    output logic              cfg_fifo_off,
    output logic              cfg_swap_dev,
    output logic              cfg_swap_mem
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam int CNT_W  = 8;

    logic [WIDX_W-1:0] widx;
    logic              hit_cmd, hit_ctrl, hit_dcnt;
    cmd_t              cmd;
    cfg_t              cfg;
    ien_t              ien;
    flags_t            flags;
    logic [REG_W-1:0]  ctrl_word, stat_word, fifo_word;
    logic [REG_W-1:0]  dcnt_q;

    assign widx     = reg_addr[ADDR_W-1:2];
    assign hit_cmd  = reg_wr && (int'(widx) == WI_CMD);
    assign hit_ctrl = reg_wr && (int'(widx) == WI_CTRL);
    assign hit_dcnt = reg_wr && (int'(widx) == WI_DCNT);

    logic unused_lo;
    assign unused_lo = ^reg_addr[1:0];

    dcr_cmd_decode u_dec (
        .hit   (hit_cmd),
        .wdata (reg_wdata),
        .cmd   (cmd)
    );

    dcr_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .chan_rst (cmd.chan_rst),
        .wr       (hit_ctrl),
        .wdata    (reg_wdata),
        .cfg      (cfg),
        .ien      (ien),
        .rd_word  (ctrl_word)
    );

    dcr_status u_stat (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .ien           (ien),
        .ev_link_done  (ev_link_done),
        .ev_chain_done (ev_chain_done),
        .ev_link_pause (ev_link_pause),
        .ev_ring_event (ev_ring_event),
        .ev_xfer_err   (ev_xfer_err),
        .drq_in        (drq_in),
        .flags         (flags),
        .run           (chan_run),
        .irq           (irq),
        .stat_word     (stat_word)
    );

    // Device-side byte counter: load wins over accumulate
    always_ff @(posedge clk) begin
        if (rst || cmd.chan_rst)
            dcnt_q <= '0;
        else if (hit_dcnt)
            dcnt_q <= reg_wdata;
        else if (ev_byte_vld)
            dcnt_q <= dcnt_q + REG_W'(ev_byte_cnt);
    end

    // FIFO occupancy view
    logic [CNT_W-1:0] fill8, empty8;
    assign fill8  = CNT_W'(fifo_fill);
    assign empty8 = CNT_W'(FIFO_DEPTH) - fill8;

    always_comb begin
        fifo_word        = '0;
        fifo_word[7:0]   = fill8;
        fifo_word[23:16] = empty8;
    end

    always_comb begin
        case (int'(widx))
            WI_CTRL: reg_rdata = ctrl_word;
            WI_DCNT: reg_rdata = dcnt_q;
            WI_FIFO: reg_rdata = fifo_word;
            WI_STAT: reg_rdata = stat_word;
            default: reg_rdata = '0;
        endcase
    end

    assign go_start     = cmd.start;
    assign go_cont      = cmd.cont;
    assign go_stop      = cmd.stop;
    assign go_abort     = cmd.abort;
    assign go_fifo_rst  = cmd.fifo_rst;
    assign cfg_mode     = cfg.mode;
    assign cfg_dir      = cfg.dir;
    assign cfg_burst    = cfg.burst;
    assign cfg_fifo_off = cfg.fifo_off;
    assign cfg_swap_dev = cfg.swap_dev;
    assign cfg_swap_mem = cfg.swap_mem;

    logic unused_fl;
    assign unused_fl = ^flags;

    // R9: a counter write takes the written value regardless of byte events
    a_r9_count_load: assert property (@(posedge clk) disable iff (rst)
        (hit_dcnt && !cmd.chan_rst) |=> (dcnt_q == $past(reg_wdata)));

    // R4: channel reset clears the byte counter
    a_r4_count_cleared: assert property (@(posedge clk) disable iff (rst)
        cmd.chan_rst |=> (dcnt_q == '0 && !chan_run));

    // R1: strobes are single-cycle pulses tied to command writes
    a_r1_strobe_source: assert property (@(posedge clk) disable iff (rst)
        (go_start || go_stop || go_abort || go_cont || go_fifo_rst) |-> hit_cmd);

endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
    localparam int DEPTH = 64;
    localparam int FW    = 7;
    localparam int BW    = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          reg_wr;
    logic [5:0]    reg_addr;
    logic [31:0]   reg_wdata, reg_rdata;
    logic          ev_link_done, ev_chain_done, ev_link_pause, ev_ring_event, ev_xfer_err;
    logic          ev_byte_vld;
    logic [BW-1:0] ev_byte_cnt;
    logic [FW-1:0] fifo_fill;
    logic [1:0]    drq_in;
    logic          irq, chan_run, go_start, go_cont, go_stop, go_abort, go_fifo_rst;
    logic [2:0]    cfg_mode;
    logic          cfg_dir, cfg_burst, cfg_fifo_off, cfg_swap_dev, cfg_swap_mem;

    dma_chan_regs u_dma_chan_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_link_done(ev_link_done), .ev_chain_done(ev_chain_done),
        .ev_link_pause(ev_link_pause), .ev_ring_event(ev_ring_event),
        .ev_xfer_err(ev_xfer_err), .ev_byte_vld(ev_byte_vld),
        .ev_byte_cnt(ev_byte_cnt), .fifo_fill(fifo_fill), .drq_in(drq_in),
        .irq(irq), .chan_run(chan_run), .go_start(go_start), .go_cont(go_cont),
        .go_stop(go_stop), .go_abort(go_abort), .go_fifo_rst(go_fifo_rst),
        .cfg_mode(cfg_mode), .cfg_dir(cfg_dir), .cfg_burst(cfg_burst),
        .cfg_fifo_off(cfg_fifo_off), .cfg_swap_dev(cfg_swap_dev),
        .cfg_swap_mem(cfg_swap_mem)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    bit [6:0]  m_en;
    bit [7:0]  m_cfg;   // {fifo_off, burst, swap_dev, swap_mem, dir, mode[2:0]}
    bit        m_run, m_lp, m_done, m_lc, m_ring, m_sw, m_hw, m_stop, m_xe;
    bit [31:0] m_cnt;
    int        set_pos[7] = '{31, 29, 25, 23, 21, 19, 17};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_en = '0; m_cfg = '0; m_run = 0; m_lp = 0; m_done = 0; m_lc = 0;
        m_ring = 0; m_sw = 0; m_hw = 0; m_stop = 0; m_xe = 0; m_cnt = '0;
    endtask

    function automatic bit exp_irq();
        return m_en[0] && ((m_lp && m_en[1]) || (m_done && m_en[2]) ||
                           (m_lc && m_en[5]) || (m_ring && m_en[6]));
    endfunction

    function automatic bit [31:0] exp_ctrl();
        bit [31:0] w = '0;
        for (int i = 0; i < 7; i++) w[set_pos[i]] = m_en[i];
        w[15] = m_cfg[7]; w[14] = m_cfg[6]; w[6] = m_cfg[5];
        w[4] = m_cfg[4]; w[3] = m_cfg[3]; w[2:0] = m_cfg[2:0];
        return w;
    endfunction

    function automatic bit [31:0] exp_stat();
        bit [31:0] w = '0;
        w[31] = exp_irq(); w[29] = m_lp; w[25] = m_done; w[19] = m_lc;
        w[17] = m_ring; w[15] = m_xe | m_hw; w[14] = m_sw; w[13] = m_hw;
        w[12] = m_stop; w[9] = m_xe; w[8] = !m_run; w[7] = drq_in[1]; w[6] = drq_in[0];
        return w;
    endfunction

    // next state from the inputs currently driven
    task automatic model_step();
        bit c = reg_wr && reg_addr[5:2] == 4'd0;
        bit st, ct, sp, ab;
        if (c && reg_wdata[31]) begin
            model_clear();
            return;
        end
        st = c && reg_wdata[0]; ct = c && reg_wdata[1];
        sp = c && reg_wdata[2]; ab = c && reg_wdata[3];
        if (reg_wr && reg_addr[5:2] == 4'd1) begin
            m_cfg = {reg_wdata[15], reg_wdata[14], reg_wdata[6], reg_wdata[4],
                     reg_wdata[3], reg_wdata[2:0]};
            for (int i = 0; i < 7; i++) begin
                if (reg_wdata[set_pos[i]-1]) m_en[i] = 0;
                else if (reg_wdata[set_pos[i]]) m_en[i] = 1;
            end
        end
        if (reg_wr && reg_addr[5:2] == 4'd2) m_cnt = reg_wdata;
        else if (ev_byte_vld) m_cnt = m_cnt + 32'(ev_byte_cnt);
        if (ev_chain_done) m_done = 1; else if ((c && reg_wdata[7]) || st) m_done = 0;
        if (ev_link_done) m_lc = 1; else if (c && reg_wdata[5]) m_lc = 0;
        if (ev_ring_event) m_ring = 1; else if (c && reg_wdata[6]) m_ring = 0;
        if (ev_link_pause) m_lp = 1; else if (ct) m_lp = 0;
        if (ev_xfer_err) begin m_xe = 1; m_hw = 1; end
        else if (st) begin m_xe = 0; m_hw = 0; end
        if (ab) m_sw = 1; else if (st) m_sw = 0;
        if (sp) m_stop = 1; else if (st) m_stop = 0;
        if (ev_xfer_err || ab || sp || ev_chain_done) m_run = 0;
        else if (st) m_run = 1;
    endtask

    // ev = {xfer_err, ring, pause, chain_done, link_done}
    task automatic step(input bit wr, input bit [5:0] a, input bit [31:0] d,
                        input bit [4:0] ev, input bit bv, input bit [7:0] bc);
        bit [4:0] exp_go;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        {ev_xfer_err, ev_ring_event, ev_link_pause, ev_chain_done, ev_link_done} = ev;
        ev_byte_vld = bv; ev_byte_cnt = bc;
        #1;
        if (wr && a[5:2] == 4'd0) begin
            exp_go = d[31] ? 5'd0 : d[4:0];
            chk("R1 strobes", {27'd0, go_fifo_rst, go_abort, go_stop, go_cont, go_start},
                {27'd0, exp_go});
        end
        model_step();
        @(posedge clk);
        #1;
        reg_wr = 0; ev_link_done = 0; ev_chain_done = 0; ev_link_pause = 0;
        ev_ring_event = 0; ev_xfer_err = 0; ev_byte_vld = 0;
    endtask

    task automatic rd(input bit [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic check_all();
        logic [31:0] v;
        bit [31:0] es;
        rd(6'h04, v);
        chk("R2/R3 control readback", v, exp_ctrl());
        chk("R2 cfg ports", {24'd0, cfg_fifo_off, cfg_burst, cfg_swap_dev, cfg_swap_mem,
                             cfg_dir, cfg_mode}, {24'd0, m_cfg});
        rd(6'h10, v);
        es = exp_stat();
        chk("R5 done/link flags", v & 32'h0208_0000, es & 32'h0208_0000);
        chk("R6 stop/abort flags", v & 32'h0000_5000, es & 32'h0000_5000);
        chk("R6 chan_run", {31'd0, chan_run}, {31'd0, m_run});
        chk("R7 error flags", v & 32'h0000_A200, es & 32'h0000_A200);
        chk("R8 status irq", v & 32'h8000_0000, es & 32'h8000_0000);
        chk("R8 irq port", {31'd0, irq}, {31'd0, exp_irq()});
        chk("R11 pause/ring/end/drq", v & 32'h2002_01C0, es & 32'h2002_01C0);
        rd(6'h08, v);
        chk("R9 byte count", v, m_cnt);
        rd(6'h0C, v);
        chk("R10 fifo word", v, {8'd0, 8'(DEPTH - int'(fifo_fill)), 8'd0, 8'(fifo_fill)});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        rst = 1; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        ev_link_done = 0; ev_chain_done = 0; ev_link_pause = 0; ev_ring_event = 0;
        ev_xfer_err = 0; ev_byte_vld = 0; ev_byte_cnt = '0; fifo_fill = 7'd10; drq_in = 2'b10;
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R4: reset state
        check_all();

        // R1: start strobe, command reads 0
        step(1, 6'h00, 32'h0000_0001, 5'd0, 0, 0);
        rd(6'h00, v);
        chk("R1 command reads zero", v, 32'd0);
        check_all();

        // R3: set all enables, then set+clear the done pair together
        step(1, 6'h04, 32'hA2AA_0000, 5'd0, 0, 0);
        check_all();
        step(1, 6'h04, 32'h0300_0000, 5'd0, 0, 0);
        check_all();
        // R3: zeros leave enables unchanged
        step(1, 6'h04, 32'h0000_C05D, 5'd0, 0, 0);
        check_all();

        // R8: done with done enable re-set
        step(1, 6'h04, 32'h8200_0000, 5'b00010, 0, 0);
        check_all();
        step(1, 6'h04, 32'h4000_0000, 5'd0, 0, 0);
        check_all();

        // R5: clear-done and chain-done in the same cycle keep done set
        step(1, 6'h00, 32'h0000_0080, 5'b00010, 0, 0);
        check_all();
        step(1, 6'h00, 32'h0000_0080, 5'd0, 0, 0);
        check_all();

        // R9: load and byte event together, then accumulate
        step(1, 6'h08, 32'd100, 5'd0, 1, 8'd5);
        check_all();
        step(0, 6'h00, 32'd0, 5'd0, 1, 8'd5);
        check_all();

        // R7: transfer error while running; R6: start with stop loses
        step(1, 6'h00, 32'h0000_0001, 5'd0, 0, 0);
        step(0, 6'h00, 32'd0, 5'b10000, 0, 0);
        check_all();
        step(1, 6'h00, 32'h0000_0005, 5'd0, 0, 0);
        check_all();

        // R10: fifo boundaries
        fifo_fill = 7'd0;  check_all();
        fifo_fill = 7'd64; check_all();

        // R4: channel reset with other bits set
        step(1, 6'h04, 32'hFFFF_FFFF, 5'b11111, 1, 8'd9);
        step(1, 6'h00, 32'h8000_00FF, 5'b11111, 1, 8'd3);
        check_all();

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit        wr = ($urandom % 100) < 55;
            bit [5:0]  a;
            bit [31:0] d = $urandom;
            int        sel = $urandom % 3;
            a = (sel == 0) ? 6'h00 : (sel == 1) ? 6'h04 : 6'h08;
            if (sel == 0) d = (($urandom % 60) == 0) ? 32'h8000_0000 : (d & 32'h0000_00FF);
            fifo_fill = 7'($urandom % (DEPTH + 1));
            drq_in = 2'($urandom);
            step(wr, a, d,
                 {(($urandom % 12) == 0), (($urandom % 6) == 0), (($urandom % 6) == 0),
                  (($urandom % 7) == 0), (($urandom % 6) == 0)},
                 (($urandom % 3) == 0), 8'($urandom));
            check_all();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule